// File: doc/BRIEF.md
# Single-Pass Raster Region Labeler

This block splits a stream of classified surface points into connected regions with one raster scan. Points arrive in row-major order, starting at the top-left corner and moving left to right, then row by row. Each point carries a plane class code and a quantized surface normal with three signed components. Each point is compared only with the point above it and the point to its left. It inherits a neighbour's label, or it receives a fresh label from a per-frame counter. When a point bridges two differently labelled neighbours, the two label sets are joined in an on-chip equivalence table.

The first pass emits a provisional label for every point, and the caller stores these labels. The table always holds each provisional label's root, which is the smallest label in its connected set. As soon as the last point of the frame has been scanned, the caller can start the second pass. It feeds each stored provisional label back in and gets the final region label one cycle later. Each point is therefore touched exactly twice. Neighbour state lives in a shift register one image row deep.

Top module: `lr_region_labeler`

## Requirements
- R1: The position counter follows the raster order, with IMG_W points per row. Points in the first row of a frame never match an upper neighbour. Points in column 0 never match a left neighbour.
- R2: Two points are similar only when their class codes are equal and, for each of the x, y and z normal components, the absolute signed difference is at most `tol_i`.
- R3: When exactly one neighbour (upper or left) is similar, the point takes that neighbour's provisional label.
- R4: When no neighbour is similar, the point takes the value of a label counter and the counter increments. The counter restarts at 0 on each frame start, so provisional labels of a frame are issued in ascending order.
- R5: When both neighbours are similar and carry different labels, the point takes the smaller label, and the two label sets are joined under the smaller root.
- R6: When a new label is needed and all N_LBL labels are already issued, the point gets label N_LBL-1 and `ovf_o` is set. `ovf_o` stays set until the next frame start.
- R7: In the second pass, `res_lbl_i` with `res_valid_i` yields `fin_valid_o` one cycle later. `fin_lbl_o` is then the smallest provisional label among all points connected to that label through chains of similar upper/left neighbour pairs.
- R8: A `frame_start_i` pulse clears `ovf_o`, the label counter and the scan position. A point presented in the same cycle as `frame_start_i` is ignored.
- R9: `lbl_valid_o` is high exactly in the cycle after an accepted point, with `lbl_o` holding that point's provisional label. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start_i | input | 1 | Pulse that begins a new frame |
| tol_i | input | NRM_W | Per-component normal tolerance, unsigned |
| pt_valid_i | input | 1 | A point is presented this cycle |
| pt_class_i | input | 2 | Plane class: 0 horizontal, 1 vertical, 2 intermediate |
| pt_nx_i | input | NRM_W | Normal x component, two's complement |
| pt_ny_i | input | NRM_W | Normal y component, two's complement |
| pt_nz_i | input | NRM_W | Normal z component, two's complement |
| lbl_valid_o | output | 1 | Provisional label valid |
| lbl_o | output | log2(N_LBL) | Provisional label of the previous accepted point |
| ovf_o | output | 1 | Label space exhausted in this frame |
| res_valid_i | input | 1 | Second-pass lookup request |
| res_lbl_i | input | log2(N_LBL) | Provisional label to resolve |
| fin_valid_o | output | 1 | Final label valid |
| fin_lbl_o | output | log2(N_LBL) | Final region label |

## Verification
The assertions check several conditions on every cycle. Every issued entry of the equivalence table points to a root that is no larger than itself and is its own parent. A join re-points the larger root, and a fresh label is its own root. Every emitted label has already been issued. The overflow flag holds until a frame start. Whether the labels form the right regions can only be shown by the bench scenarios, which compare each provisional label and each resolved label with a model computed from the requirements. These scenarios cover U- and comb-shaped regions whose arms join late, normal gradients around the tolerance edge, and a checkerboard that exhausts the label space.

// File: rtl/lr_pkg.sv
package lr_pkg;
  parameter int CLS_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_HORIZ = 2'd0,
    CLS_VERT  = 2'd1,
    CLS_INTER = 2'd2,
    CLS_SPARE = 2'd3
  } plane_cls_e;

  localparam int NB_TOP  = 0;
  localparam int NB_LEFT = 1;
  localparam int NB_CNT  = 2;
endpackage

// File: rtl/lr_sim_cmp.sv
module lr_sim_cmp #(
  parameter int NRM_W = 4,
  parameter int CLS_W = 2
) (
  input  logic               en_i,
  input  logic [CLS_W-1:0]   a_cls_i,
  input  logic [3*NRM_W-1:0] a_nrm_i,
  input  logic [CLS_W-1:0]   b_cls_i,
  input  logic [3*NRM_W-1:0] b_nrm_i,
  input  logic [NRM_W-1:0]   tol_i,
  output logic               match_o
);
  logic [2:0] comp_ok;

  for (genvar c = 0; c < 3; c++) begin : g_comp
    logic signed [NRM_W:0] diff;
    logic        [NRM_W:0] mag;
    always_comb begin
      diff = $signed({a_nrm_i[c*NRM_W+NRM_W-1], a_nrm_i[c*NRM_W +: NRM_W]})
           - $signed({b_nrm_i[c*NRM_W+NRM_W-1], b_nrm_i[c*NRM_W +: NRM_W]});
      mag  = diff[NRM_W] ? $unsigned(-diff) : $unsigned(diff);
      comp_ok[c] = (mag <= {1'b0, tol_i});
    end
  end

  assign match_o = en_i && (a_cls_i == b_cls_i) && (&comp_ok);
endmodule

// File: rtl/lr_line_buf.sv
module lr_line_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] left_o,
  output logic [DW-1:0] top_o
);
  logic [DW-1:0] sr_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [DW-1:0] nxt;
    if (s == 0) begin : g_head
      assign nxt = din_i;
    end else begin : g_body
      assign nxt = sr_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sr_q[s] <= '0;
      else if (push_i) sr_q[s] <= nxt;
    end
  end

  assign left_o = sr_q[0];
  assign top_o  = sr_q[DEPTH-1];
endmodule

// File: rtl/lr_equiv_tbl.sv
module lr_equiv_tbl #(
  parameter int N_LBL = 16,
  parameter int LBL_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] n_alloc_i,
  input  logic             alloc_en_i,
  input  logic [LBL_W-1:0] alloc_lbl_i,
  input  logic             merge_en_i,
  input  logic [LBL_W-1:0] lbl_a_i,
  input  logic [LBL_W-1:0] lbl_b_i,
  input  logic             look_en_i,
  input  logic [LBL_W-1:0] look_lbl_i,
  output logic             fin_valid_o,
  output logic [LBL_W-1:0] fin_lbl_o
);
  logic [LBL_W-1:0] par_q [N_LBL];
  logic [LBL_W-1:0] par_d [N_LBL];
  logic [LBL_W-1:0] root_a, root_b, lo, hi;
  logic             do_merge;
  logic             fin_valid_q;
  logic [LBL_W-1:0] fin_lbl_q, fin_lbl_d;

  always_comb begin
    root_a   = par_q[lbl_a_i];
    root_b   = par_q[lbl_b_i];
    lo       = (root_a < root_b) ? root_a : root_b;
    hi       = (root_a < root_b) ? root_b : root_a;
    do_merge = merge_en_i && (root_a != root_b);
    for (int i = 0; i < N_LBL; i++) begin
      par_d[i] = par_q[i];
      if (do_merge && (par_q[i] == hi)) par_d[i] = lo;
    end
    if (alloc_en_i) par_d[alloc_lbl_i] = alloc_lbl_i;
    fin_lbl_d = look_en_i ? par_q[look_lbl_i] : fin_lbl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LBL; i++) par_q[i] <= '0;
    end else if (alloc_en_i || do_merge) begin
      for (int i = 0; i < N_LBL; i++) par_q[i] <= par_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin_valid_q <= 1'b0;
      fin_lbl_q   <= '0;
    end else begin
      fin_valid_q <= look_en_i;
      fin_lbl_q   <= fin_lbl_d;
    end
  end

  assign fin_valid_o = fin_valid_q;
  assign fin_lbl_o   = fin_lbl_q;

  for (genvar gi = 0; gi < N_LBL; gi++) begin : g_chk
    AST_TBL_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (CNT_W'(gi) < n_alloc_i) |-> ((par_q[par_q[gi]] == par_q[gi]) && (par_q[gi] <= LBL_W'(gi))))
      else $error("table entry not flat"); // R7
  end

  AST_JOIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    do_merge |=> (par_q[$past(hi)] == $past(lo)))
    else $error("join did not re-point larger root"); // R5

  AST_ALLOC_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en_i |=> (par_q[$past(alloc_lbl_i)] == $past(alloc_lbl_i)))
    else $error("fresh label not its own root"); // R4

  AST_FIN_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    look_en_i |=> fin_valid_o)
    else $error("second-pass result late"); // R7
endmodule

// File: rtl/lr_region_labeler.sv
module lr_region_labeler
  import lr_pkg::*;
#(
  parameter int IMG_W = 8,
  parameter int N_LBL = 16,
  parameter int NRM_W = 4,
  localparam int LBL_W = $clog2(N_LBL),
  localparam int CNT_W = $clog2(N_LBL + 1),
  localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1,
  localparam int NRM3  = 3 * NRM_W,
  localparam int DW    = CLS_W + NRM3 + LBL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start_i,
  input  logic [NRM_W-1:0] tol_i,
  input  logic             pt_valid_i,
  input  logic [CLS_W-1:0] pt_class_i,
  input  logic [NRM_W-1:0] pt_nx_i,
  input  logic [NRM_W-1:0] pt_ny_i,
  input  logic [NRM_W-1:0] pt_nz_i,
  output logic             lbl_valid_o,
  output logic [LBL_W-1:0] lbl_o,
  output logic             ovf_o,
  input  logic             res_valid_i,
  input  logic [LBL_W-1:0] res_lbl_i,
  output logic             fin_valid_o,
  output logic [LBL_W-1:0] fin_lbl_o
);
  // scan state
  logic [COL_W-1:0] col_q, col_d;
  logic             row1_q, row1_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             lbl_vld_q;
  logic [LBL_W-1:0] lbl_q;

  logic             acc, col_last, full;
  logic [NRM3-1:0]  cur_nrm;
  logic [DW-1:0]    nb_w [NB_CNT];
  logic [NB_CNT-1:0] nb_en, nb_hit;
  logic [LBL_W-1:0] top_lbl, left_lbl, lbl_sel;
  logic             need_new, alloc_en, merge_en;
  logic [DW-1:0]    push_w;

  assign acc      = pt_valid_i && !frame_start_i;
  assign col_last = (col_q == COL_W'(IMG_W - 1));
  assign full     = (cnt_q == CNT_W'(N_LBL));
  assign cur_nrm  = {pt_nz_i, pt_ny_i, pt_nx_i};
  assign nb_en[NB_TOP]  = !row1_q;
  assign nb_en[NB_LEFT] = (col_q != '0);
  assign top_lbl  = nb_w[NB_TOP][LBL_W-1:0];
  assign left_lbl = nb_w[NB_LEFT][LBL_W-1:0];

  for (genvar n = 0; n < NB_CNT; n++) begin : g_nb
    lr_sim_cmp #(.NRM_W(NRM_W), .CLS_W(CLS_W)) u_cmp (
      .en_i    (nb_en[n]),
      .a_cls_i (pt_class_i),
      .a_nrm_i (cur_nrm),
      .b_cls_i (nb_w[n][LBL_W+NRM3 +: CLS_W]),
      .b_nrm_i (nb_w[n][LBL_W +: NRM3]),
      .tol_i   (tol_i),
      .match_o (nb_hit[n])
    );
  end

  always_comb begin
    need_new = !nb_hit[NB_TOP] && !nb_hit[NB_LEFT];
    merge_en = acc && nb_hit[NB_TOP] && nb_hit[NB_LEFT] && (top_lbl != left_lbl);
    alloc_en = acc && need_new && !full;
    if (nb_hit[NB_TOP] && nb_hit[NB_LEFT])
      lbl_sel = (top_lbl < left_lbl) ? top_lbl : left_lbl;
    else if (nb_hit[NB_TOP])  lbl_sel = top_lbl;
    else if (nb_hit[NB_LEFT]) lbl_sel = left_lbl;
    else if (full)            lbl_sel = LBL_W'(N_LBL - 1);
    else                      lbl_sel = cnt_q[LBL_W-1:0];
    push_w = {pt_class_i, cur_nrm, lbl_sel};
  end

  // next-state for scan position, counter, overflow
  always_comb begin
    col_d  = col_q;
    row1_d = row1_q;
    cnt_d  = cnt_q;
    ovf_d  = ovf_q;
    if (frame_start_i) begin
      col_d  = '0;
      row1_d = 1'b1;
      cnt_d  = '0;
      ovf_d  = 1'b0;
    end else if (acc) begin
      col_d  = col_last ? '0 : col_q + 1'b1;
      row1_d = row1_q && !col_last;
      if (alloc_en) cnt_d = cnt_q + 1'b1;
      if (need_new && full) ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row1_q <= 1'b1;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (frame_start_i || acc) begin
      col_q  <= col_d;
      row1_q <= row1_d;
      cnt_q  <= cnt_d;
      ovf_q  <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbl_vld_q <= 1'b0;
      lbl_q     <= '0;
    end else begin
      lbl_vld_q <= acc;
      if (acc) lbl_q <= lbl_sel;
    end
  end

  lr_line_buf #(.DEPTH(IMG_W), .DW(DW)) u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (acc),
    .din_i  (push_w),
    .left_o (nb_w[NB_LEFT]),
    .top_o  (nb_w[NB_TOP])
  );

  lr_equiv_tbl #(.N_LBL(N_LBL), .LBL_W(LBL_W), .CNT_W(CNT_W)) u_tbl (
    .clk         (clk),
    .rst_n       (rst_n),
    .n_alloc_i   (cnt_q),
    .alloc_en_i  (alloc_en),
    .alloc_lbl_i (cnt_q[LBL_W-1:0]),
    .merge_en_i  (merge_en),
    .lbl_a_i     (top_lbl),
    .lbl_b_i     (left_lbl),
    .look_en_i   (res_valid_i),
    .look_lbl_i  (res_lbl_i),
    .fin_valid_o (fin_valid_o),
    .fin_lbl_o   (fin_lbl_o)
  );

  assign lbl_valid_o = lbl_vld_q;
  assign lbl_o       = lbl_q;
  assign ovf_o       = ovf_q;

  AST_FIRST_PT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && row1_q && (col_q == '0) && !full) |=> (lbl_o == $past(cnt_q[LBL_W-1:0])))
    else $error("corner point did not get a fresh label"); // R1

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(N_LBL))
    else $error("label counter out of range"); // R4

  AST_LBL_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_valid_o |-> ({1'b0, lbl_o} < {1'b0, cnt_q}))
    else $error("emitted label never issued"); // R4

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !frame_start_i) |=> ovf_o)
    else $error("overflow flag dropped"); // R6

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> ($past(cnt_q) == CNT_W'(N_LBL)))
    else $error("overflow without full counter"); // R6

  AST_FRAME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> (!ovf_o && (cnt_q == '0) && !lbl_valid_o))
    else $error("frame start did not clear state"); // R8

  AST_LBL_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> lbl_valid_o)
    else $error("label valid missing"); // R9

  AST_LBL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !lbl_valid_o)
    else $error("label valid without point"); // R9
endmodule

// File: tb/lr_region_labeler_tb_top.sv
module lr_region_labeler_tb_top;
  localparam int W  = 8;
  localparam int H  = 6;
  localparam int NP = W * H;
  localparam int NL = 16;
  localparam int NW = 4;
  localparam int LW = 4;

  logic clk;
  logic rst_n;
  logic frame_start_i;
  logic [NW-1:0] tol_i;
  logic pt_valid_i;
  logic [1:0] pt_class_i;
  logic [NW-1:0] pt_nx_i, pt_ny_i, pt_nz_i;
  logic lbl_valid_o;
  logic [LW-1:0] lbl_o;
  logic ovf_o;
  logic res_valid_i;
  logic [LW-1:0] res_lbl_i;
  logic fin_valid_o;
  logic [LW-1:0] fin_lbl_o;

  lr_region_labeler #(.IMG_W(W), .N_LBL(NL), .NRM_W(NW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i), .tol_i(tol_i),
    .pt_valid_i(pt_valid_i), .pt_class_i(pt_class_i),
    .pt_nx_i(pt_nx_i), .pt_ny_i(pt_ny_i), .pt_nz_i(pt_nz_i),
    .lbl_valid_o(lbl_valid_o), .lbl_o(lbl_o), .ovf_o(ovf_o),
    .res_valid_i(res_valid_i), .res_lbl_i(res_lbl_i),
    .fin_valid_o(fin_valid_o), .fin_lbl_o(fin_lbl_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cls_a [NP];
  int nx_a  [NP];
  int ny_a  [NP];
  int nz_a  [NP];
  int lab_m [NP];
  int fin_m [NP];
  int kind_m[NP];
  int tol_m;
  bit ovf_m;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // R2: equal class and every component within tolerance
  function automatic bit simp(int a, int b);
    if (cls_a[a] != cls_a[b]) return 0;
    if (iabs(nx_a[a] - nx_a[b]) > tol_m) return 0;
    if (iabs(ny_a[a] - ny_a[b]) > tol_m) return 0;
    if (iabs(nz_a[a] - nz_a[b]) > tol_m) return 0;
    return 1;
  endfunction

  task automatic build(int p);
    for (int i = 0; i < NP; i++) begin
      int x = i % W;
      int y = i / W;
      cls_a[i] = 0; nx_a[i] = 0; ny_a[i] = 0; nz_a[i] = 0;
      case (p)
        1: cls_a[i] = (x / 2) % 3;
        2: cls_a[i] = (x == 0 || x == W-1 || y == H-1) ? 1 : 0;
        3: cls_a[i] = (x + y) % 2;
        4: nx_a[i] = x - 4;
        5: begin ny_a[i] = (y % 3) - 1; nz_a[i] = (x % 2) * 2; end
        6: begin cls_a[i] = (((x*3 + y*5) % 7) < 3) ? 1 : 2; nx_a[i] = ((x*y) % 3) - 1; end
        7: cls_a[i] = (((x + 1) % 3 == 0) || y == H-1) ? 1 : 0;
        default: ;
      endcase
    end
  endtask

  // provisional labels from R1-style raster rules, final labels by relaxation
  task automatic model();
    int cnt = 0;
    bit changed = 1;
    ovf_m = 0;
    for (int i = 0; i < NP; i++) begin
      int x = i % W;
      int y = i / W;
      bit mt = (y > 0) && simp(i, i - W);
      bit ml = (x > 0) && simp(i, i - 1);
      if (mt && ml) begin
        lab_m[i] = (lab_m[i-W] < lab_m[i-1]) ? lab_m[i-W] : lab_m[i-1]; kind_m[i] = 2;
      end else if (mt) begin
        lab_m[i] = lab_m[i-W]; kind_m[i] = 1;
      end else if (ml) begin
        lab_m[i] = lab_m[i-1]; kind_m[i] = 1;
      end else if (cnt < NL) begin
        lab_m[i] = cnt; cnt++; kind_m[i] = 0;
      end else begin
        lab_m[i] = NL - 1; ovf_m = 1; kind_m[i] = 3;
      end
    end
    for (int i = 0; i < NP; i++) fin_m[i] = lab_m[i];
    while (changed) begin
      changed = 0;
      for (int i = 0; i < NP; i++) begin
        int x = i % W;
        int y = i / W;
        if (y > 0 && simp(i, i - W) && fin_m[i] != fin_m[i-W]) begin
          int m = (fin_m[i] < fin_m[i-W]) ? fin_m[i] : fin_m[i-W];
          fin_m[i] = m; fin_m[i-W] = m; changed = 1;
        end
        if (x > 0 && simp(i, i - 1) && fin_m[i] != fin_m[i-1]) begin
          int m = (fin_m[i] < fin_m[i-1]) ? fin_m[i] : fin_m[i-1];
          fin_m[i] = m; fin_m[i-1] = m; changed = 1;
        end
      end
    end
  endtask

  task automatic run_frame(int p, int tol, string ftag);
    build(p);
    tol_m = tol;
    model();
    tol_i = NW'(tol);
    frame_start_i = 1'b1;
    pt_valid_i = 1'b1;          // R8: point during frame start is dropped
    pt_class_i = 2'd3;
    @(negedge clk);
    frame_start_i = 1'b0;
    pt_valid_i = 1'b0;
    chk("R8 ovf cleared", int'(ovf_o), 0);
    chk("R8 dropped point", int'(lbl_valid_o), 0);
    for (int i = 0; i < NP; i++) begin
      string rq;
      int x = i % W;
      int y = i / W;
      pt_valid_i = 1'b1;
      pt_class_i = 2'(cls_a[i]);
      pt_nx_i = NW'(nx_a[i]);
      pt_ny_i = NW'(ny_a[i]);
      pt_nz_i = NW'(nz_a[i]);
      @(negedge clk);
      case (kind_m[i])
        0: rq = "R4";
        1: rq = "R3";
        2: rq = "R5";
        default: rq = "R6";
      endcase
      if (x == 0 || y == 0) rq = {rq, "/R1"};
      rq = {rq, "/", ftag};
      chk("R9 label valid", int'(lbl_valid_o), 1);
      chk(rq, int'(lbl_o), lab_m[i]);
    end
    pt_valid_i = 1'b0;
    @(negedge clk);
    chk("R9 idle", int'(lbl_valid_o), 0);
    chk("R6 overflow flag", int'(ovf_o), int'(ovf_m));
    if (!ovf_m) begin
      for (int i = 0; i < NP; i++) begin
        res_valid_i = 1'b1;
        res_lbl_i = LW'(lab_m[i]);
        @(negedge clk);
        chk("R7 valid", int'(fin_valid_o), 1);
        chk({"R7 root/", ftag}, int'(fin_lbl_o), fin_m[i]);
      end
      res_valid_i = 1'b0;
      @(negedge clk);
      chk("R7 idle", int'(fin_valid_o), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    frame_start_i = 1'b0;
    tol_i = '0;
    pt_valid_i = 1'b0;
    pt_class_i = '0;
    pt_nx_i = '0; pt_ny_i = '0; pt_nz_i = '0;
    res_valid_i = 1'b0;
    res_lbl_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset label valid", int'(lbl_valid_o), 0);
    chk("R7 reset fin valid", int'(fin_valid_o), 0);
    chk("R8 reset ovf", int'(ovf_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_frame(0, 0, "R3");
    run_frame(1, 0, "R1");
    run_frame(2, 0, "R5");
    run_frame(3, 0, "R6");
    run_frame(0, 0, "R8");
    run_frame(4, 0, "R2");
    run_frame(4, 1, "R2");
    run_frame(5, 1, "R2");
    run_frame(5, 2, "R2");
    run_frame(6, 0, "R2");
    run_frame(6, 1, "R2");
    run_frame(7, 0, "R5");
    run_frame(7, 3, "R5");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule